// File: doc/BRIEF.md
# Pass-Based Microcode Fetch Sequencer

This block produces instruction-fetch addresses for a small dedicated signal processor whose whole program is run once for every input multiplexer cycle. A start strobe loads the program counter with index zero and captures an 8-bit page selector. The selector places the program on a 1 KB boundary of a shared program memory. The sequencer then asks for one 16-bit word at a time. A request advances only while the memory grant is high. The sequencer waits for the word to come back before it asks for the next one.

A returned word equal to the halt opcode ends the pass. The sequencer then stays quiet until the next start strobe. A pass that is still running when the cycle-end strobe arrives, when a new start strobe arrives, or when it reaches the last program word without a halt is cut short. Any of these cases sets a sticky overrun flag. The host clears that flag by writing a one to the clear input.

Top module: `fetch_seq`

## Requirements
- R1: While reset is held and after it is released, the outputs fetch_req, busy, pass_done and overrun are all 0.
- R2: A cyc_start pulse captures base_sel and begins a pass at program index 0. The fetch for index n is presented at byte address 1024·base_sel + 2·n, and indices advance one at a time.
- R3: A fetch is taken only in a cycle where fetch_req and mem_gnt are both high. While mem_gnt is low, fetch_req stays high and fetch_addr does not change.
- R4: Only one fetch is outstanding at a time. After a fetch is taken, fetch_req is low until instr_valid returns a word. An instr_valid that arrives while no fetch is awaited is ignored.
- R5: A returned word equal to the halt opcode (default 16'h0000) ends the pass. On the next edge, busy falls and pass_done is high for exactly one cycle. No fetch is requested until the next cyc_start.
- R6: cyc_end during a pass aborts the pass and sets overrun on the same edge. cyc_end while idle has no effect.
- R7: If the word at index 4095 (the last of 4096) is not a halt, the pass stops, overrun is set and pass_done stays low. A halt at index 4095 ends the pass normally.
- R8: overrun stays set until ovr_clr is pulsed high. If a set and a clear happen in the same cycle, the set wins.
- R9: A cyc_start during a running pass sets overrun and restarts the pass at index 0 with the newly captured base_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cyc_start | input | 1 | Multiplexer cycle start strobe |
| cyc_end | input | 1 | Multiplexer cycle end strobe |
| base_sel | input | 8 | Program page selector (1 KB units) |
| mem_gnt | input | 1 | Shared memory grant for this cycle |
| fetch_req | output | 1 | Fetch request |
| fetch_addr | output | 19 | Byte address of requested word |
| instr_valid | input | 1 | Returned instruction word is valid |
| instr_data | input | 16 | Returned instruction word |
| busy | output | 1 | A pass is in progress |
| pass_done | output | 1 | One-cycle pulse after a halt ends a pass |
| ovr_clr | input | 1 | Write-one-to-clear for overrun |
| overrun | output | 1 | Sticky missed-deadline flag |

## Verification
fetch_req and the address for index 0 appear one edge after a start strobe. Each later index appears one edge after the previous word returns. busy, pass_done and overrun change on the edge that samples the halt word, the limit word or the strobe that ends the pass. The bench drives inputs just after the falling edge and samples half a cycle before the next rising edge, so every result is read in the first cycle it is due. The memory model answers exactly one edge after a granted fetch, and the monitor counts a fetch only in a cycle where the sequencer actually takes it. This lets the fetch counts be compared exactly, apart from the abort case, which is checked against a range.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_t;

  // byte address of a program word: page base plus word offset
  function automatic logic [31:0] word_byte_addr(input logic [31:0] page,
                                                 input logic [31:0] idx,
                                                 input int unsigned page_bytes,
                                                 input int unsigned word_bytes);
    return page * page_bytes + idx * word_bytes;
  endfunction

endpackage

// File: rtl/fseq_ovr.sv
module fseq_ovr (
  input  logic clk,
  input  logic rst_n,
  input  logic set_abort,
  input  logic set_limit,
  input  logic clr,
  output logic flag
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    flag_q <= 1'b0;
    else if (set_abort || set_limit) flag_q <= 1'b1;
    else if (clr)                  flag_q <= 1'b0;
  end

  assign flag = flag_q;

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr |=> flag_q);

  assert_set_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_abort || set_limit));

endmodule

// File: rtl/fseq_pc.sv
module fseq_pc #(
  parameter int LOC_W      = 8,
  parameter int PROG_WORDS = 4096,
  parameter int PAGE_BYTES = 1024,
  parameter int WORD_BYTES = 2,
  parameter int ADDR_W     = 19,
  localparam int PC_W      = $clog2(PROG_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pc_load,
  input  logic              pc_inc,
  input  logic [LOC_W-1:0]  base_sel,
  output logic              pc_last,
  output logic [ADDR_W-1:0] fetch_addr
);
  import fseq_pkg::*;

  localparam logic [PC_W-1:0] LAST_IDX = PC_W'(PROG_WORDS - 1);

  logic [PC_W-1:0]  pc_q;
  logic [LOC_W-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      base_q <= '0;
    end else if (pc_load) begin
      pc_q   <= '0;
      base_q <= base_sel;
    end else if (pc_inc) begin
      pc_q   <= pc_q + PC_W'(1);
    end
  end

  assign pc_last    = (pc_q == LAST_IDX);
  assign fetch_addr = ADDR_W'(word_byte_addr(32'(base_q), 32'(pc_q), PAGE_BYTES, WORD_BYTES));

  assert_inc_below_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc |-> !pc_last);

  assert_addr_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_load && !pc_inc |=> $stable(fetch_addr));

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl #(
  parameter int WORD_W = 16,
  parameter logic [WORD_W-1:0] HALT_OP = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic              cyc_end,
  input  logic              mem_gnt,
  input  logic              instr_valid,
  input  logic [WORD_W-1:0] instr_data,
  input  logic              pc_last,
  output logic              pc_load,
  output logic              pc_inc,
  output logic              fetch_req,
  output logic              busy,
  output logic              pass_done,
  output logic              abort_evt,
  output logic              limit_evt
);
  import fseq_pkg::*;

  seq_state_t st_q, st_n;
  logic done_q;
  logic running, word_in, is_halt, quiet, halt_hit;

  always_comb begin
    running   = (st_q != ST_IDLE);
    word_in   = (st_q == ST_WAIT) && instr_valid;
    is_halt   = (instr_data == HALT_OP);
    quiet     = !cyc_start && !cyc_end;
    abort_evt = running && !quiet;
    halt_hit  = word_in && is_halt && quiet;
    limit_evt = word_in && !is_halt && pc_last && quiet;
    pc_inc    = word_in && !is_halt && !pc_last && quiet;
    pc_load   = cyc_start;
    fetch_req = (st_q == ST_FETCH);
  end

  always_comb begin
    st_n = st_q;
    if (cyc_start)    st_n = ST_FETCH;
    else if (cyc_end) st_n = ST_IDLE;
    else begin
      unique case (st_q)
        ST_FETCH: if (mem_gnt) st_n = ST_WAIT;
        ST_WAIT:  if (instr_valid) st_n = (is_halt || pc_last) ? ST_IDLE : ST_FETCH;
        default:  st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      done_q <= halt_hit;
    end
  end

  assign busy      = running;
  assign pass_done = done_q;

  assert_halt_ends_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    halt_hit |=> !busy && pass_done);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |=> !pass_done);

  assert_one_outstanding_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && mem_gnt && quiet |=> !fetch_req);

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !cyc_start |=> !fetch_req);

endmodule

// File: rtl/fetch_seq.sv
module fetch_seq #(
  parameter int LOC_W      = 8,
  parameter int PROG_WORDS = 4096,
  parameter int WORD_W     = 16,
  parameter logic [WORD_W-1:0] HALT_OP = '0,
  parameter int PAGE_BYTES = 1024,
  localparam int WORD_BYTES = WORD_W / 8,
  localparam int ADDR_W = $clog2(((1 << LOC_W) - 1) * PAGE_BYTES + (PROG_WORDS - 1) * WORD_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic              cyc_end,
  input  logic [LOC_W-1:0]  base_sel,
  input  logic              mem_gnt,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              instr_valid,
  input  logic [WORD_W-1:0] instr_data,
  output logic              busy,
  output logic              pass_done,
  input  logic              ovr_clr,
  output logic              overrun
);
  logic pc_load, pc_inc, pc_last, abort_evt, limit_evt;

  fseq_ctrl #(.WORD_W(WORD_W), .HALT_OP(HALT_OP)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_end(cyc_end),
    .mem_gnt(mem_gnt), .instr_valid(instr_valid), .instr_data(instr_data),
    .pc_last(pc_last), .pc_load(pc_load), .pc_inc(pc_inc),
    .fetch_req(fetch_req), .busy(busy), .pass_done(pass_done),
    .abort_evt(abort_evt), .limit_evt(limit_evt)
  );

  fseq_pc #(.LOC_W(LOC_W), .PROG_WORDS(PROG_WORDS), .PAGE_BYTES(PAGE_BYTES),
            .WORD_BYTES(WORD_BYTES), .ADDR_W(ADDR_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .pc_load(pc_load), .pc_inc(pc_inc),
    .base_sel(base_sel), .pc_last(pc_last), .fetch_addr(fetch_addr)
  );

  fseq_ovr u_ovr (
    .clk(clk), .rst_n(rst_n), .set_abort(abort_evt), .set_limit(limit_evt),
    .clr(ovr_clr), .flag(overrun)
  );

  assert_stall_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !mem_gnt && !cyc_start && !cyc_end |=> fetch_req && $stable(fetch_addr));

  assert_restart_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cyc_start |=> overrun && busy);

endmodule

// File: tb/sim_fetch_seq.sv
`timescale 1ns/1ps
module sim_fetch_seq;
  logic clk = 0, rst_n = 0, cyc_start = 0, cyc_end = 0, mem_gnt = 1;
  logic instr_valid = 0, ovr_clr = 0;
  logic [7:0]  base_sel = 0;
  logic [15:0] instr_data = 0;
  logic fetch_req, busy, pass_done, overrun;
  logic [18:0] fetch_addr;

  int checks = 0, failures = 0;
  int cur_base = 0, halt_idx = 0, exp_idx = 0, fetch_count = 0, done_count = 0;
  int gnt_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic inj_valid = 0;
  logic [15:0] inj_data = 0;

  always #10 clk = ~clk;

  fetch_seq u0 (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_end(cyc_end),
    .base_sel(base_sel), .mem_gnt(mem_gnt), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .instr_valid(instr_valid), .instr_data(instr_data),
    .busy(busy), .pass_done(pass_done), .ovr_clr(ovr_clr), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] prog_word(input int idx);
    if (idx == halt_idx) return 16'h0000;
    return {4'h5, idx[11:0]};
  endfunction

  // memory model: answers one edge after a granted fetch
  always @(posedge clk) begin
    instr_valid <= (fetch_req && mem_gnt) || inj_valid;
    instr_data  <= inj_valid ? inj_data : prog_word((int'(fetch_addr) - cur_base * 1024) / 2);
  end

  always @(negedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_gnt = (gnt_mode == 0) ? 1'b1 : (gnt_mode == 1) ? (lfsr[0] | lfsr[3]) : 1'b0;
  end

  // monitor: fetches that the sequencer takes at the coming edge
  always @(negedge clk) begin
    #5;
    if (rst_n && fetch_req && mem_gnt && !cyc_start && !cyc_end) begin
      chk(fetch_addr == 19'(cur_base * 1024 + 2 * exp_idx), "R2", "fetch address",
          longint'(fetch_addr), longint'(cur_base * 1024 + 2 * exp_idx));
      exp_idx++;
      fetch_count++;
    end
    if (pass_done) done_count++;
  end

  task automatic start_pass(input int b, input int h);
    @(negedge clk); #1;
    cur_base = b; halt_idx = h; exp_idx = 0; fetch_count = 0; done_count = 0;
    base_sel = 8'(b); cyc_start = 1;
    @(negedge clk); #1;
    cyc_start = 0;
  endtask

  task automatic finish_pass(input int exp_fetch, input int exp_done, input string req);
    int n = 0;
    do begin @(negedge clk); #6; n++; end while (busy && n < 20000);
    chk(!busy, req, "pass ended", busy, 0);
    chk(fetch_count == exp_fetch, req, "fetch count", fetch_count, exp_fetch);
    chk(done_count == exp_done, req, "done pulses", done_count, exp_done);
  endtask

  task automatic pulse_clr;
    @(negedge clk); #1 ovr_clr = 1;
    @(negedge clk); #1 ovr_clr = 0;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 180000, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!fetch_req, "R1", "fetch_req in reset", fetch_req, 0);
    chk(!busy, "R1", "busy in reset", busy, 0);
    chk(!overrun && !pass_done, "R1", "flags in reset", overrun, 0);
    @(negedge clk); #1 rst_n = 1;
    @(negedge clk); #6;
    chk(!busy && !fetch_req && !overrun, "R1", "after reset", busy, 0);

    // R2 every page, short programs
    for (int b = 0; b < 256; b++) begin
      start_pass(b, b % 6);
      finish_pass(b % 6 + 1, 1, "R2");
    end
    chk(!overrun, "R5", "no overrun after normal passes", overrun, 0);

    // R3 random grant
    gnt_mode = 1;
    for (int k = 0; k < 20; k++) begin
      start_pass((k * 13) % 256, 7 + k);
      finish_pass(8 + k, 1, "R3");
    end
    gnt_mode = 2;
    @(negedge clk);
    start_pass(77, 3);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #6;
      chk(fetch_req && fetch_addr == 19'(77 * 1024), "R3", "stalled request held",
          longint'(fetch_addr), 77 * 1024);
    end
    // R4 stray word while no fetch awaited
    @(negedge clk); #1 inj_valid = 1; inj_data = 16'h0000;
    @(negedge clk); #1 inj_valid = 0;
    repeat (2) @(negedge clk); #6;
    chk(busy && fetch_req, "R4", "stray halt ignored", busy, 1);
    gnt_mode = 0;
    finish_pass(4, 1, "R4");

    // R5 silent after halt
    begin
      int seen = 0;
      for (int i = 0; i < 30; i++) begin @(negedge clk); #6; if (fetch_req) seen++; end
      chk(seen == 0, "R5", "requests while idle", seen, 0);
    end
    // R4 stray word while idle
    @(negedge clk); #1 inj_valid = 1; inj_data = 16'h1234;
    @(negedge clk); #1 inj_valid = 0;
    repeat (3) @(negedge clk); #6;
    chk(!busy && !fetch_req, "R4", "stray word while idle", busy, 0);

    // R6 cyc_end while idle
    @(negedge clk); #1 cyc_end = 1;
    @(negedge clk); #1 cyc_end = 0;
    @(negedge clk); #6;
    chk(!overrun, "R6", "idle cyc_end no effect", overrun, 0);

    // R6 abort, with clear in same cycle (R8 set wins)
    start_pass(5, 3000);
    repeat (40) @(negedge clk);
    #1 cyc_end = 1; ovr_clr = 1;
    @(negedge clk); #1 cyc_end = 0; ovr_clr = 0;
    #5;
    chk(!busy, "R6", "aborted pass idle", busy, 0);
    chk(overrun, "R8", "set beats clear", overrun, 1);
    chk(done_count == 0, "R6", "no done on abort", done_count, 0);
    chk(fetch_count >= 15 && fetch_count <= 41, "R6", "fetches before abort", fetch_count, 20);

    // R8 sticky across a normal pass, then cleared
    start_pass(6, 2);
    finish_pass(3, 1, "R8");
    chk(overrun, "R8", "overrun sticky", overrun, 1);
    pulse_clr();
    #5;
    chk(!overrun, "R8", "overrun cleared", overrun, 0);

    // R9 restart during a pass
    start_pass(3, 3000);
    repeat (30) @(negedge clk);
    #1;
    cur_base = 9; halt_idx = 4; exp_idx = 0; fetch_count = 0; done_count = 0;
    base_sel = 8'd9; cyc_start = 1;
    @(negedge clk); #1 cyc_start = 0;
    #5;
    chk(overrun && busy, "R9", "restart flags overrun", overrun, 1);
    finish_pass(5, 1, "R9");
    pulse_clr();

    // R7 program limit
    start_pass(200, 99999);
    finish_pass(4096, 0, "R7");
    chk(overrun, "R7", "limit sets overrun", overrun, 1);
    pulse_clr();
    start_pass(201, 4095);
    finish_pass(4096, 1, "R7");
    chk(!overrun, "R7", "halt at last word", overrun, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule